// File: doc/BRIEF.md
# Error-Report Correction Applier

This block takes the error reports produced by a block-code decoder and applies them to a payload held in its own buffer RAM. The buffer is organised as 16-bit units. A host fills the buffer through a plain memory port. A report file of 32-bit entries is loaded, and then a start pulse is given together with the decoder's status word. The sequencer checks the uncorrectable and error flags in that word, then walks the entries in slot order. For each entry it reads the addressed unit, XORs the entry's flip mask into it and writes the result back.

When the job ends, the block gives a one-cycle done pulse together with a corrected-bit count, an uncorrectable flag and a sticky out-of-range flag. The host port and the report file accept no access while a job runs. Both edges are plain request/strobe interfaces with no back-pressure, so the caller must leave them idle until busy falls. A host read returns its data in the cycle after the request.

Top module: `ecc_fixup_engine`

## Requirements
- R1: After reset, done, busy, uncorrectable, range_err and corr_count are all zero.
- R2: A report entry holds the flip mask in bits 31:16 and the 16-bit unit index in bits 10:0. Applying an entry replaces unit[index] with unit[index] XOR mask, so the mask's low byte lands on byte 2*index and its high byte on byte 2*index+1.
- R3: The number of entries to apply comes from status bits 30:24. Entries are taken from slot 0 upward in strictly ascending order, so two entries that hit the same unit are both applied, in sequence.
- R4: When status bit 1 (uncorrectable) is set, no unit is modified, uncorrectable reads 1 and corr_count reads 0.
- R5: When status bit 1 is clear and status bit 0 (error) is clear, no unit is modified and corr_count reads 0.
- R6: When corrections run, corr_count reports status bits 22:16 (total errors), not the entry count.
- R7: An entry whose index is not below payload_units, or not below the buffer depth, is skipped and sets range_err. range_err holds until the next accepted start clears it.
- R8: An entry count above the report file size (64 slots) is clamped to the file size and sets range_err.
- R9: A start pulse that arrives while busy is high has no effect on the running job and produces no extra done.
- R10: done stays high for exactly one cycle per accepted start.
- R11: Host reads and writes are ignored while busy is high.
- R12: Each in-range entry takes one read cycle followed by one write cycle, and each skipped entry takes one cycle. Busy therefore stays high for 2*applied + skipped + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_we | input | 1 | Report file write strobe |
| rpt_waddr | input | 6 | Report slot to write |
| rpt_wdata | input | 32 | Report entry (mask 31:16, index 10:0) |
| start | input | 1 | Begin a job using status |
| status | input | 32 | Decoder status word |
| payload_units | input | 12 | Payload length in 16-bit units |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 10 | Host unit address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after request |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| corr_count | output | 7 | Corrected-bit count of the last job |
| uncorrectable | output | 1 | Last job was uncorrectable |
| range_err | output | 1 | Sticky skipped-entry / clamp flag |

## Verification
The hardest case to reach is an event that arrives in the middle of a long job: a second start, or a host write, issued while the sequencer is still walking the clamped 64-entry list. To reach it, the bench starts a job whose status requests 100 entries. A few cycles later it drives an uncorrectable status with a fresh start and a host write to an untouched unit. It then checks that the result, the busy length and that unit all match the first job alone. Repeated indices and out-of-range indices placed between valid ones exercise the ordering and skip paths.

// File: rtl/ecc_fixup_pkg.sv
package ecc_fixup_pkg;
  localparam int CNT_W  = 7;
  localparam int IDX_W  = 11;
  localparam int MASK_W = 16;

  localparam int ST_ERR   = 0;
  localparam int ST_UNCOR = 1;
  localparam int ST_TERR  = 16;
  localparam int ST_NENT  = 24;

  typedef struct packed {
    logic [MASK_W-1:0]      mask;
    logic [31-MASK_W-IDX_W:0] rsvd;
    logic [IDX_W-1:0]       idx;
  } fix_entry_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} fix_state_e;
endpackage

// File: rtl/fixup_report_regs.sv
module fixup_report_regs
  import ecc_fixup_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [31:0]       wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output fix_entry_t        rd_entry
);
  fix_entry_t slots_q [SLOTS];

  // loads are refused mid-job so the walked list cannot change under the sequencer
  always_ff @(posedge clk) begin
    if (wr_en && !busy) slots_q[wr_slot] <= fix_entry_t'(wr_data);
  end

  assign rd_entry = slots_q[rd_slot];
endmodule

// File: rtl/fixup_payload_ram.sv
module fixup_payload_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          eng_re,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [15:0]   eng_wdata,
  output logic [15:0]   eng_rdata,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata
);
  logic [15:0] mem [DEPTH];
  logic        host_ok;

  assign host_ok = host_en && !busy;

  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_addr] <= eng_wdata;
    else if (eng_re) eng_rdata <= mem[eng_addr];
    if (host_ok && host_we) mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_ok && !host_we) host_rdata <= mem[host_addr];
  end

  // R11: a request made during a job leaves the read data untouched
  a_r11_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_en) |=> $stable(host_rdata));
endmodule

// File: rtl/fixup_sequencer.sv
module fixup_sequencer
  import ecc_fixup_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int DEPTH = 1024,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       status,
  input  logic [IDX_W:0]    payload_units,
  output logic [SLOT_W-1:0] slot_sel,
  input  fix_entry_t        entry,
  output logic              ram_re,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [15:0]       ram_wdata,
  input  logic [15:0]       ram_rdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  corr_count,
  output logic              uncorrectable,
  output logic              range_err
);
  localparam logic [CNT_W-1:0] SLOT_LIM = CNT_W'(SLOTS);

  fix_state_e        state_q;
  logic [31:0]       status_q;
  logic [CNT_W-1:0]  nent_q, slot_q, nent_raw;
  logic [AW-1:0]     addr_q;
  logic [15:0]       mask_q;
  logic              last, in_range;
  logic              unused_rsvd;

  assign unused_rsvd = ^entry.rsvd;
  assign nent_raw = status[ST_NENT +: CNT_W];
  assign last     = (slot_q == nent_q - 1'b1);
  assign in_range = ({1'b0, entry.idx} < payload_units) && (32'(entry.idx) < DEPTH);
  assign slot_sel = slot_q[SLOT_W-1:0];

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign ram_re    = (state_q == S_RD) && in_range;
  assign ram_we    = (state_q == S_WR);
  assign ram_addr  = (state_q == S_WR) ? addr_q : entry.idx[AW-1:0];
  assign ram_wdata = ram_rdata ^ mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      status_q      <= '0;
      nent_q        <= '0;
      slot_q        <= '0;
      addr_q        <= '0;
      mask_q        <= '0;
      corr_count    <= '0;
      uncorrectable <= 1'b0;
      range_err     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          status_q  <= status;
          range_err <= 1'b0;
          slot_q    <= '0;
          if (status[ST_UNCOR]) begin
            uncorrectable <= 1'b1;
            corr_count    <= '0;
            state_q       <= S_FIN;
          end else if (!status[ST_ERR]) begin
            uncorrectable <= 1'b0;
            corr_count    <= '0;
            state_q       <= S_FIN;
          end else begin
            uncorrectable <= 1'b0;
            corr_count    <= status[ST_TERR +: CNT_W];
            if (nent_raw > SLOT_LIM) begin
              nent_q    <= SLOT_LIM;
              range_err <= 1'b1;
            end else begin
              nent_q <= nent_raw;
            end
            state_q <= (nent_raw == '0) ? S_FIN : S_RD;
          end
        end
        S_RD: begin
          if (in_range) begin
            addr_q  <= entry.idx[AW-1:0];
            mask_q  <= entry.mask;
            state_q <= S_WR;
          end else begin
            range_err <= 1'b1;
            if (last) state_q <= S_FIN;
            else slot_q <= slot_q + 1'b1;
          end
        end
        S_WR: begin
          if (last) state_q <= S_FIN;
          else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r12_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR) |-> ($past(state_q) == S_RD));
  a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(status_q));
  a_r4_no_write_uncor: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !status_q[ST_UNCOR]);
  a_r8_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD) |-> (slot_q < SLOT_LIM));
endmodule

// File: rtl/ecc_fixup_engine.sv
module ecc_fixup_engine
  import ecc_fixup_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int DEPTH = 1024,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_we,
  input  logic [SLOT_W-1:0] rpt_waddr,
  input  logic [31:0]       rpt_wdata,
  input  logic              start,
  input  logic [31:0]       status,
  input  logic [IDX_W:0]    payload_units,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  corr_count,
  output logic              uncorrectable,
  output logic              range_err
);
  logic [SLOT_W-1:0] slot_sel;
  fix_entry_t        entry;
  logic              ram_re, ram_we;
  logic [AW-1:0]     ram_addr;
  logic [15:0]       ram_wdata, ram_rdata;

  fixup_report_regs #(.SLOTS(SLOTS)) u_regs (
    .clk(clk), .busy(busy), .wr_en(rpt_we), .wr_slot(rpt_waddr),
    .wr_data(rpt_wdata), .rd_slot(slot_sel), .rd_entry(entry)
  );

  fixup_sequencer #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .status(status),
    .payload_units(payload_units), .slot_sel(slot_sel), .entry(entry),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy), .done(done),
    .corr_count(corr_count), .uncorrectable(uncorrectable), .range_err(range_err)
  );

  fixup_payload_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .eng_re(ram_re), .eng_we(ram_we), .eng_addr(ram_addr),
    .eng_wdata(ram_wdata), .eng_rdata(ram_rdata),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );
endmodule

// File: tb/ecc_fixup_engine_bench.sv
module ecc_fixup_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rpt_we = 1'b0;
  logic [5:0]  rpt_waddr = '0;
  logic [31:0] rpt_wdata = '0;
  logic        start = 1'b0;
  logic [31:0] status = '0;
  logic [11:0] payload_units = 12'd128;
  logic        host_en = 1'b0, host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy, done, uncorrectable, range_err;
  logic [6:0]  corr_count;

  ecc_fixup_engine u_ecc_fixup_engine (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [6:0] count;
    logic       uncor;
    logic       oor;
    int         cycles;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model [128];
  int          checks = 0, fails = 0, busy_cnt = 0, dones = 0;
  logic        prev_done = 1'b0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_status(input logic unc, input logic err,
                                            input logic [6:0] n, input logic [6:0] terr);
    return {1'b0, n, 1'b0, terr, 14'b0, unc, err};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_slot(input int s, input logic [15:0] mask, input logic [10:0] idx);
    tick(); rpt_we = 1'b1; rpt_waddr = 6'(s); rpt_wdata = {mask, 5'b0, idx};
    tick(); rpt_we = 1'b0;
  endtask

  task automatic host_write(input int a, input logic [15:0] d);
    tick(); host_en = 1'b1; host_we = 1'b1; host_addr = 10'(a); host_wdata = d;
    tick(); host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [15:0] d);
    tick(); host_en = 1'b1; host_we = 1'b0; host_addr = 10'(a);
    tick(); host_en = 1'b0; d = host_rdata;
  endtask

  task automatic verify_mem(input string tag);
    logic [15:0] d;
    for (int i = 0; i < 128; i++) begin
      host_read(i, d);
      check(d == model[i], tag, d, model[i]);
    end
  endtask

  // driver: pushes the expected result, fires the job, optionally disturbs it mid-run
  task automatic run_job(input logic [31:0] st, input logic [6:0] ecount, input logic eunc,
                         input logic eoor, input int ecyc, input logic poke);
    exp_t e;
    e.count = ecount; e.uncor = eunc; e.oor = eoor; e.cycles = ecyc;
    sb_q.push_back(e);
    tick(); start = 1'b1; status = st;
    tick(); start = 1'b0;
    if (poke) begin
      repeat (4) tick();
      start = 1'b1; status = mk_status(1'b1, 1'b1, 7'd3, 7'd1);
      host_en = 1'b1; host_we = 1'b1; host_addr = 10'd100; host_wdata = 16'hdead;
      tick(); start = 1'b0; host_en = 1'b0; host_we = 1'b0;
    end
    do @(negedge clk); while (busy);
    tick();
  endtask

  // monitor: pops and compares on each done
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!done, "R10 done single cycle", done, 0);
      if (busy) busy_cnt++;
      if (done) begin
        dones++;
        if (sb_q.size() == 0) check(1'b0, "R9 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(corr_count == e.count, "R6 corr_count", corr_count, e.count);
          check(uncorrectable == e.uncor, "R4 uncorrectable", uncorrectable, e.uncor);
          check(range_err == e.oor, "R7 range_err", range_err, e.oor);
          check(busy_cnt == e.cycles, "R12 busy length", busy_cnt, e.cycles);
        end
        busy_cnt = 0;
      end
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !busy, "R1 done/busy after reset", {done, busy}, 0);
    check(!uncorrectable && !range_err, "R1 flags after reset", {uncorrectable, range_err}, 0);
    check(corr_count == 0, "R1 count after reset", corr_count, 0);

    for (int i = 0; i < 128; i++) begin
      model[i] = 16'(i * 771) ^ 16'h5a5a;
      host_write(i, model[i]);
    end
    verify_mem("R11 host fill");

    // R2/R3: repeated index applied twice, in order
    write_slot(0, 16'h00ff, 11'd3);
    write_slot(1, 16'h8100, 11'd10);
    write_slot(2, 16'h0f0f, 11'd3);
    model[3] ^= 16'h00ff; model[10] ^= 16'h8100; model[3] ^= 16'h0f0f;
    run_job(mk_status(1'b0, 1'b1, 7'd3, 7'd5), 7'd5, 1'b0, 1'b0, 7, 1'b0);
    verify_mem("R2 R3 xor applied");

    // R4: uncorrectable, entries present
    run_job(mk_status(1'b1, 1'b1, 7'd3, 7'd5), 7'd0, 1'b1, 1'b0, 1, 1'b0);
    verify_mem("R4 nothing applied");

    // R5: error bit clear
    run_job(mk_status(1'b0, 1'b0, 7'd3, 7'd5), 7'd0, 1'b0, 1'b0, 1, 1'b0);
    verify_mem("R5 nothing applied");

    // R7: out-of-range index between valid ones
    payload_units = 12'd20;
    write_slot(0, 16'h00ff, 11'd5);
    write_slot(1, 16'hffff, 11'd25);
    write_slot(2, 16'hff00, 11'd19);
    model[5] ^= 16'h00ff; model[19] ^= 16'hff00;
    run_job(mk_status(1'b0, 1'b1, 7'd3, 7'd2), 7'd2, 1'b0, 1'b1, 6, 1'b0);
    verify_mem("R7 skip out of range");
    payload_units = 12'd128;

    // R8/R9/R11: clamp 100 -> 64, disturbed mid-job
    for (int i = 0; i < 64; i++) begin
      write_slot(i, 16'(i * 37 + 1), 11'(i));
      model[i] ^= 16'(i * 37 + 1);
    end
    run_job(mk_status(1'b0, 1'b1, 7'd100, 7'd9), 7'd9, 1'b0, 1'b1, 129, 1'b1);
    verify_mem("R8 R9 R11 clamp and blocked host");

    // R7 clear on new start; R6 with zero entries
    run_job(mk_status(1'b0, 1'b1, 7'd0, 7'd4), 7'd4, 1'b0, 1'b0, 1, 1'b0);
    verify_mem("R6 zero entries");

    repeat (5) tick();
    check(sb_q.size() == 0 && dones == 6, "R9 done count", dones, 6);
    finish_run();
  end
endmodule